// File: doc/BRIEF.md
# Auto-Reload 8-bit Interval Timer

This block is an 8-bit down counter paired with a reload register. It turns a chosen stream of count pulses into a periodic underflow event. Each underflow raises an interrupt request flag. Four count-source enables arrive as single-cycle pulses on the system clock, and a 2-bit select picks one of them. Counting happens only while the run input is high.

Software loads the count through a write port. While the timer is stopped, a write sets the counter and the reload register together. While it runs, a write changes only the reload register, and the new period starts at the next underflow. The count can be read back at any time, but the value is only defined while the timer is stopped. The flag stays set until it is cleared, either by interrupt acceptance or by a skip-test that consumes it.

Top module: `reload_timer8`

## Requirements
- R1: After a synchronous active-low reset, the count output is 0, the reload register holds 0 and the flag is 0.
- R2: A write while run is low loads the written value into the counter and the reload register in the same clock edge.
- R3: A write while run is high changes only the reload register. The counter keeps its sequence, and the new value is loaded at the next underflow.
- R4: While run is high, each selected count pulse lowers the counter by exactly one. Cycles without a selected pulse leave the counter unchanged.
- R5: A selected pulse that arrives while the counter is 0 is an underflow. The counter then reloads from the reload register, so a reload value n gives one underflow every n+1 pulses, for n from 0 to 255.
- R6: Select value k (0 to 3) makes source pulse bit k the only count source. Pulses on the other three bits have no effect.
- R7: While run is low, count pulses are ignored and the counter holds its value.
- R8: Every underflow sets the flag to 1 on the same clock edge. The flag then stays at 1 until it is cleared.
- R9: A clear pulse sets the flag to 0 on the next edge. If a clear and an underflow fall on the same cycle, the flag ends at 1.
- R10: While run is low, the count output equals the counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Count enable (run bit) |
| src_sel | input | 2 | Count source select; value k picks src_pulse[k] |
| src_pulse | input | 4 | Single-cycle count-source enable pulses |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Write value for counter and/or reload register |
| flag_clr | input | 1 | Flag clear from interrupt acceptance or skip-test |
| count_q | output | 8 | Counter read-back |
| irq_flag | output | 1 | Interrupt request flag |

## Verification
The assertions check the per-cycle rules on every cycle: a decrement of one per selected pulse, the reload on a pulse at zero, the counter holding while stopped, the two write paths, and the set, hold and clear of the flag with set taking priority. Only the bench scenarios can show the end-to-end period of n+1 pulses, including the extreme reload values 0 and 255. The same applies to a reload value written while running that takes effect only after the following underflow, and to pulses on unselected sources leaving no trace when the counter is read back.

// File: rtl/itimer_pkg.sv
// Package: shared defaults and the counter action encoding for the interval timer.
// Assumes: nothing; pure type and constant definitions.
package itimer_pkg;
    localparam int unsigned CNT_W_DEF = 8;
    localparam int unsigned NSRC_DEF  = 4;

    // Next-state action chosen for the down counter each cycle.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_DEC    = 2'd2,
        ACT_RELOAD = 2'd3
    } cnt_act_e;
endpackage

// File: rtl/itimer_src_sel.sv
// Module: picks one of NSRC count-source pulses and gates it with the run bit.
// Assumes: source pulses are single-cycle enables on the system clock;
//          a select value at or above NSRC selects no source.
module itimer_src_sel #(
    parameter int unsigned NSRC  = 4,
    parameter int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             run_en,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [NSRC-1:0]  src_pulse,
    output logic             tick
);
    logic [NSRC-1:0] hit;

    // One-hot match of the select value against each source index.
    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_src
            assign hit[gi] = (src_sel == SEL_W'(gi)) & src_pulse[gi];
        end
    endgenerate

    // Count tick: a selected pulse while running.
    always_comb begin
        tick = run_en & (|hit);
    end
endmodule

// File: rtl/itimer_counter.sv
// Module: down counter with reload register and underflow detection.
// Assumes: tick is already gated by the run bit; a write while stopped loads
//          both registers, a write while running loads only the reload register.
module itimer_counter
    import itimer_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] rld_q,
    output logic             uflow
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_act_e act;

    // Underflow: a tick arriving while the counter already holds zero.
    always_comb begin
        uflow = tick & (cnt_q == ZERO);
    end

    // Choose the counter action for this cycle.
    always_comb begin
        if (!run_en && wr_en)  act = ACT_LOAD;
        else if (uflow)        act = ACT_RELOAD;
        else if (tick)         act = ACT_DEC;
        else                   act = ACT_HOLD;
    end

    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else begin
            unique case (act)
                ACT_LOAD:   cnt_q <= wr_data;
                ACT_RELOAD: cnt_q <= rld_q;
                ACT_DEC:    cnt_q <= cnt_q - ONE;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    // Reload register: every write lands here, running or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= ZERO;
        end else if (wr_en) begin
            rld_q <= wr_data;
        end
    end
endmodule

// File: rtl/itimer_flag.sv
// Module: interrupt request flag, set by underflow, cleared by acceptance.
// Assumes: set and clear are single-cycle; set wins when both are present.
module itimer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    // Flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/reload_timer8.sv
// Module: auto-reload interval timer top; an underflow every n+1 selected pulses.
// Assumes: one system clock; sources are single-cycle enables; read-back is
//          meaningful only while run_en is low.
module reload_timer8
    import itimer_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF,
    parameter int unsigned NSRC  = NSRC_DEF,
    localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [NSRC-1:0]  src_pulse,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_flag
);
    logic             tick;
    logic             uflow;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;

    itimer_src_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) src_i (
        .run_en    (run_en),
        .src_sel   (src_sel),
        .src_pulse (src_pulse),
        .tick      (tick)
    );

    itimer_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cnt_q   (cnt_q),
        .rld_q   (rld_q),
        .uflow   (uflow)
    );

    itimer_flag flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (uflow),
        .clr_i  (flag_clr),
        .flag_q (irq_flag)
    );

    // Read-back path straight from the counter.
    always_comb begin
        count_q = cnt_q;
    end
endmodule

// File: rtl/reload_timer8_chk.sv
// Module: property checker for the interval timer, bound to the top module.
// Assumes: observes ports plus the reload register; checks are disabled in reset.
module reload_timer8_chk #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned NSRC  = 4,
    parameter int unsigned SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic [SEL_W-1:0] src_sel,
    input logic [NSRC-1:0]  src_pulse,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count_q,
    input logic             irq_flag,
    input logic [CNT_W-1:0] rld_q
);
    logic sel_pulse;
    logic at_zero;

    // Selected pulse and zero state as seen from the ports.
    always_comb begin
        sel_pulse = run_en && (int'(src_sel) < NSRC) && src_pulse[src_sel];
        at_zero   = (count_q == '0);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (count_q == '0 && !irq_flag && rld_q == '0));

    // R2
    stop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && wr_en) |=> (count_q == $past(wr_data) && rld_q == $past(wr_data)));

    // R3
    run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && wr_en && !sel_pulse) |=> ($stable(count_q) && rld_q == $past(wr_data)));

    // R4
    dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_pulse && !at_zero) |=> (count_q == $past(count_q) - 1'b1));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_pulse && at_zero) |=> (count_q == $past(rld_q)));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> $stable(count_q));

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_pulse && at_zero) |=> irq_flag);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(sel_pulse && at_zero)) |=> !irq_flag);
endmodule

bind reload_timer8 reload_timer8_chk #(.CNT_W(CNT_W), .NSRC(NSRC), .SEL_W(SEL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .src_sel   (src_sel),
    .src_pulse (src_pulse),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flag_clr  (flag_clr),
    .count_q   (count_q),
    .irq_flag  (irq_flag),
    .rld_q     (rld_q)
);

// File: tb/reload_timer8_tb_top.sv
// Bench: scoreboard; driver tasks queue expected values, a monitor compares at negedge.
module reload_timer8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] src_pulse = 4'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       flag_clr = 1'b0;
    logic [7:0] count_q;
    logic       irq_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit        is_flag;
        int        exp;
        string     req;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    reload_timer8 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .src_sel   (src_sel),
        .src_pulse (src_pulse),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .flag_clr  (flag_clr),
        .count_q   (count_q),
        .irq_flag  (irq_flag)
    );

    // Monitor: pops queued expectations and compares them away from the edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            int act;
            it = sb_q.pop_front();
            act = it.is_flag ? int'(irq_flag) : int'(count_q);
            n_checks++;
            if (act != it.exp) begin
                n_errors++;
                $display("FAIL %s %s actual=%0d expected=%0d", it.req,
                         it.is_flag ? "flag" : "count", act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        flag_clr = 1'b0;
        src_pulse = 4'd0;
    endtask

    task automatic exp_cnt(input int v, input string req);
        sb_q.push_back('{is_flag: 1'b0, exp: v, req: req});
    endtask

    task automatic exp_flag(input int v, input string req);
        sb_q.push_back('{is_flag: 1'b1, exp: v, req: req});
    endtask

    task automatic write(input int v);
        wr_en = 1'b1;
        wr_data = 8'(v);
        step();
    endtask

    task automatic pulses(input int n, input int bitpos);
        for (int i = 0; i < n; i++) begin
            src_pulse = 4'(1 << bitpos);
            step();
        end
    endtask

    task automatic stop_read(input int v, input string req);
        run_en = 1'b0;
        step();
        exp_cnt(v, req);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #1;
        step();
        step();
        rst_n = 1'b1;
        step();
        exp_cnt(0, "R1");
        exp_flag(0, "R1");

        // R2: stopped write loads the counter
        write(5);
        exp_cnt(5, "R2");

        // R7: pulses ignored while stopped
        src_sel = 2'd0;
        pulses(3, 0);
        exp_cnt(5, "R7");

        // R6: unselected sources ignored while running
        run_en = 1'b1;
        pulses(1, 1);
        pulses(1, 2);
        pulses(1, 3);
        stop_read(5, "R6");

        // R4 and R10: three selected pulses take 5 down to 2
        run_en = 1'b1;
        pulses(3, 0);
        stop_read(2, "R4_R10");

        // R5 and R8: reach zero without a flag, the next pulse underflows
        run_en = 1'b1;
        pulses(2, 0);
        exp_flag(0, "R5");
        pulses(1, 0);
        exp_flag(1, "R8");
        stop_read(5, "R5");

        // R8: flag holds with no clear
        step();
        step();
        exp_flag(1, "R8");

        // R9: clear
        flag_clr = 1'b1;
        step();
        exp_flag(0, "R9");

        // R3: running write changes only the reload register
        run_en = 1'b1;
        write(2);
        stop_read(5, "R3");
        run_en = 1'b1;
        pulses(5, 0);
        exp_flag(0, "R3");
        pulses(1, 0);
        exp_flag(1, "R3");
        stop_read(2, "R3");

        // R9: set wins against a simultaneous clear (counter 2, flag 1)
        run_en = 1'b1;
        pulses(2, 0);
        src_pulse = 4'b0001;
        flag_clr = 1'b1;
        step();
        exp_flag(1, "R9");
        flag_clr = 1'b1;
        step();
        exp_flag(0, "R9");

        // R5: reload of 0 underflows on every pulse
        run_en = 1'b0;
        write(0);
        run_en = 1'b1;
        pulses(1, 0);
        exp_flag(1, "R5");
        flag_clr = 1'b1;
        step();
        exp_flag(0, "R5");
        pulses(1, 0);
        exp_flag(1, "R5");
        stop_read(0, "R5");

        // R4: gapped pulses on source 2
        write(6);
        flag_clr = 1'b1;
        step();
        src_sel = 2'd2;
        run_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            pulses(1, 2);
            step();
        end
        stop_read(2, "R4");

        // R5 and R6: reload 255 on source 3 gives a 256-pulse period
        write(255);
        src_sel = 2'd3;
        run_en = 1'b1;
        pulses(255, 3);
        exp_flag(0, "R5");
        pulses(1, 3);
        exp_flag(1, "R5");
        stop_read(255, "R5");

        step();
        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule